// File: doc/BRIEF.md
# Console CPU Bus Address Decoder

This block sits on the 16-bit address bus of an 8-bit console processor. It turns each bus access into the chip selects and access strobes for the memory-map targets, and it returns the read byte from whichever target the address falls in. It contains the 2 KB work RAM. Every other target stays outside and is reached through plain select, strobe and data ports: the graphics register window, the two controller ports, the sprite-DMA trigger, cartridge battery RAM and cartridge program ROM. Targets that need the address or write byte take them directly from `cpu_addr` and `cpu_wdata`.

An access is presented for one cycle with `cpu_req` high. `cpu_we` marks it as a write. On a read, `cpu_dummy` marks a dummy read. That is a bus cycle whose data is thrown away. It still reaches the graphics window, because reads there have side effects, but it does not disturb the controllers. Chip selects and `cpu_rdata` follow the address combinationally. Strobes rise only in the cycle of a valid access.

A free-running cycle counter counts bus accesses. The DMA engine has a separate read port into the work RAM, and traffic on that port is not counted.

Top module: `cpu_bus_decoder`

## Requirements
- R1: Addresses 0x0000–0x1FFF reach the work RAM, indexed only by address bits 10:0. A byte written at one address reads back at every address that differs from it only in bits 12:11.
- R2: Addresses 0x2000–0x3FFF assert `ppu_sel` and return `ppu_rdata`. A read in that range (dummy or not) pulses `ppu_rd`, and a write pulses `ppu_wr`.
- R3: Addresses 0x6000–0x7FFF assert `cram_sel` and return `cram_rdata`. A write there pulses `cram_wr`.
- R4: Addresses 0x8000–0xFFFF assert `crom_sel` and return `crom_rdata`.
- R5: A write at 0x8000 or above pulses `crom_wr`, so the cartridge logic sees it. It is never dropped.
- R6: A write to 0x4014 raises `dma_go` for exactly the following cycle, and `dma_page` takes the written byte from that cycle on. `dma_page` is unchanged by any other access.
- R7: A non-dummy read of 0x4016 returns `pad0_rdata` and pulses `pad_rd[0]`. A non-dummy read of 0x4017 returns `pad1_rdata` and pulses `pad_rd[1]`. A write to 0x4016 pulses `pad_wr`.
- R8: A read of any other address from 0x4000 to 0x5FFF (0x4014 included) returns 0x00 and raises no strobe.
- R9: `cyc_count` advances by one, modulo 2^CYC_W, in the cycle after every access with `cpu_req` high: read, write or dummy read.
- R10: `dma_ram_rdata` returns the RAM byte at `dma_ram_addr`, and use of that port never changes `cyc_count`.
- R11: A dummy read pulses no controller strobe (`pad_rd` stays 0).
- R12: With `cpu_req` low, none of `ppu_rd`, `ppu_wr`, `pad_rd`, `pad_wr`, `cram_wr`, `crom_wr` is raised, and neither the RAM nor the DMA trigger is written.
- R13: After reset, `cyc_count` is 0, `dma_go` is 0 and `dma_page` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Bus access valid this cycle |
| cpu_we | input | 1 | Access is a write |
| cpu_dummy | input | 1 | Read is a dummy read |
| cpu_addr | input | 16 | Bus address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte from the addressed target |
| cyc_count | output | CYC_W | Bus access counter |
| ppu_sel | output | 1 | Graphics register window selected |
| ppu_rd | output | 1 | Graphics window read strobe |
| ppu_wr | output | 1 | Graphics window write strobe |
| ppu_rdata | input | 8 | Graphics window read byte |
| pad_rd | output | 2 | Controller read strobes, bit n for port n |
| pad_wr | output | 1 | Controller latch-register write strobe |
| pad0_rdata | input | 8 | Controller port 0 read byte |
| pad1_rdata | input | 8 | Controller port 1 read byte |
| dma_go | output | 1 | Sprite DMA start pulse |
| dma_page | output | 8 | Sprite DMA source page |
| dma_ram_addr | input | 11 | DMA engine RAM read index |
| dma_ram_rdata | output | 8 | DMA engine RAM read byte |
| cram_sel | output | 1 | Cartridge RAM selected |
| cram_wr | output | 1 | Cartridge RAM write strobe |
| cram_rdata | input | 8 | Cartridge RAM read byte |
| crom_sel | output | 1 | Cartridge ROM space selected |
| crom_wr | output | 1 | Cartridge ROM-space write strobe |
| crom_rdata | input | 8 | Cartridge ROM read byte |

## Verification
The whole RAM is first filled through rotating mirror addresses, so that each later read through another mirror shows whether bits 12:11 are really ignored. Directed sweeps then cover every region edge (0x1FFF/0x2000, 0x3FFF/0x4000, 0x4013–0x4018, 0x5FFF/0x6000, 0x7FFF/0x8000). These separate the exact-match registers from their unmapped neighbours and from the range decodes. Dummy reads and idle cycles are placed on the graphics window and the controller ports to show which strobes a side-effect-free access may raise. Back-to-back DMA writes, and a long mixed run with a narrow counter, show the pulse timing, the page hold and the counter wrap, all while the DMA RAM port is active.

// File: rtl/cpu_bus_pkg.sv
package cpu_bus_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_WRAM,
        RG_PPU,
        RG_DMA,
        RG_PAD0,
        RG_PAD1,
        RG_CRAM,
        RG_CROM
    } bus_region_e;

    typedef struct packed {
        logic              dma_go;
        logic [DATA_W-1:0] dma_page;
    } trig_state_t;

endpackage

// File: rtl/cbd_addr_decode.sv
module cbd_addr_decode
    import cpu_bus_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] RAM_TOP   = 16'h2000,
    parameter logic [15:0] PPU_TOP   = 16'h4000,
    parameter logic [15:0] DMA_REG   = 16'h4014,
    parameter logic [15:0] PAD0_REG  = 16'h4016,
    parameter logic [15:0] CRAM_BASE = 16'h6000,
    parameter logic [15:0] CROM_BASE = 16'h8000
) (
    input  logic [ADDR_W-1:0] addr,
    output bus_region_e       region
);
    localparam logic [15:0] PAD1_REG = PAD0_REG + 16'd1;

    always_comb begin
        if (addr >= CROM_BASE)      region = RG_CROM;
        else if (addr < RAM_TOP)    region = RG_WRAM;
        else if (addr < PPU_TOP)    region = RG_PPU;
        else if (addr >= CRAM_BASE) region = RG_CRAM;
        else if (addr == DMA_REG)   region = RG_DMA;
        else if (addr == PAD0_REG)  region = RG_PAD0;
        else if (addr == PAD1_REG)  region = RG_PAD1;
        else                        region = RG_NONE;
    end

endmodule

// File: rtl/cbd_work_ram.sv
module cbd_work_ram #(
    parameter int AW  = 11,
    parameter int DW  = 8,
    parameter int NRD = 2
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [DW-1:0]          wdata,
    input  logic [NRD-1:0][AW-1:0] raddr,
    output logic [NRD-1:0][DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem_q[raddr[p]];
    end

endmodule

// File: rtl/cbd_cycle_ctr.sv
module cbd_cycle_ctr #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [CW-1:0] count
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (cnt_q == CW'($past(cnt_q) + CW'(1))));

    assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt_q));

endmodule

// File: rtl/cpu_bus_decoder.sv
module cpu_bus_decoder
    import cpu_bus_pkg::*;
#(
    parameter int CYC_W  = 32,
    parameter int RAM_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_dummy,
    input  logic [15:0]       cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [CYC_W-1:0]  cyc_count,
    output logic              ppu_sel,
    output logic              ppu_rd,
    output logic              ppu_wr,
    input  logic [DATA_W-1:0] ppu_rdata,
    output logic [1:0]        pad_rd,
    output logic              pad_wr,
    input  logic [DATA_W-1:0] pad0_rdata,
    input  logic [DATA_W-1:0] pad1_rdata,
    output logic              dma_go,
    output logic [DATA_W-1:0] dma_page,
    input  logic [RAM_AW-1:0] dma_ram_addr,
    output logic [DATA_W-1:0] dma_ram_rdata,
    output logic              cram_sel,
    output logic              cram_wr,
    input  logic [DATA_W-1:0] cram_rdata,
    output logic              crom_sel,
    output logic              crom_wr,
    input  logic [DATA_W-1:0] crom_rdata
);
    localparam int          RD_PORTS = 2;
    localparam logic [15:0] DMA_ADDR = 16'h4014;

    bus_region_e region;
    trig_state_t st_d, st_q;

    logic rd_acc, real_rd, wr_acc, ram_we;
    logic [RD_PORTS-1:0][RAM_AW-1:0] ram_raddr;
    logic [RD_PORTS-1:0][DATA_W-1:0] ram_rdata;

    cbd_addr_decode #(.ADDR_W(16)) u_decode (
        .addr   (cpu_addr),
        .region (region)
    );

    assign ram_raddr[0] = cpu_addr[RAM_AW-1:0];
    assign ram_raddr[1] = dma_ram_addr;

    cbd_work_ram #(.AW(RAM_AW), .DW(DATA_W), .NRD(RD_PORTS)) u_wram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (cpu_addr[RAM_AW-1:0]),
        .wdata (cpu_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    cbd_cycle_ctr #(.CW(CYC_W)) u_cycles (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cpu_req),
        .count (cyc_count)
    );

    // access qualifiers
    assign rd_acc  = cpu_req & ~cpu_we;
    assign real_rd = rd_acc & ~cpu_dummy;
    assign wr_acc  = cpu_req & cpu_we;

    // selects follow the address alone; strobes need a valid access
    always_comb begin
        ppu_sel   = (region == RG_PPU);
        cram_sel  = (region == RG_CRAM);
        crom_sel  = (region == RG_CROM);
        ram_we    = wr_acc & (region == RG_WRAM);
        ppu_rd    = rd_acc & ppu_sel;
        ppu_wr    = wr_acc & ppu_sel;
        pad_rd[0] = real_rd & (region == RG_PAD0);
        pad_rd[1] = real_rd & (region == RG_PAD1);
        pad_wr    = wr_acc & (region == RG_PAD0);
        cram_wr   = wr_acc & cram_sel;
        crom_wr   = wr_acc & crom_sel;
    end

    // read return mux
    always_comb begin
        unique case (region)
            RG_WRAM: cpu_rdata = ram_rdata[0];
            RG_PPU:  cpu_rdata = ppu_rdata;
            RG_PAD0: cpu_rdata = pad0_rdata;
            RG_PAD1: cpu_rdata = pad1_rdata;
            RG_CRAM: cpu_rdata = cram_rdata;
            RG_CROM: cpu_rdata = crom_rdata;
            default: cpu_rdata = '0;
        endcase
    end

    // DMA trigger register
    always_comb begin
        st_d        = st_q;
        st_d.dma_go = wr_acc & (region == RG_DMA);
        if (st_d.dma_go) st_d.dma_page = cpu_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dma_go        = st_q.dma_go;
    assign dma_page      = st_q.dma_page;
    assign dma_ram_rdata = ram_rdata[1];

    assert_dma_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_go |-> $past(cpu_req && cpu_we && (cpu_addr == DMA_ADDR)));

    assert_dma_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cpu_req && cpu_we && (cpu_addr == DMA_ADDR)) |-> $stable(dma_page));

    assert_strobe_needs_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ppu_rd || ppu_wr || pad_wr || cram_wr || crom_wr || (pad_rd != 2'b00)) |-> cpu_req);

    assert_dummy_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_dummy && !cpu_we) |-> (pad_rd == 2'b00));

    assert_rom_write_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && cpu_addr[15]) |-> crom_wr);

endmodule

// File: tb/tb_cpu_bus_decoder.sv
`timescale 1ns/1ps
module tb_cpu_bus_decoder;
    localparam int CW = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, cpu_req, cpu_we, cpu_dummy;
    logic [15:0] cpu_addr;
    logic [7:0] cpu_wdata, cpu_rdata, ppu_rdata, pad0_rdata, pad1_rdata;
    logic [7:0] dma_page, dma_ram_rdata, cram_rdata, crom_rdata;
    logic [CW-1:0] cyc_count;
    logic ppu_sel, ppu_rd, ppu_wr, pad_wr, dma_go, cram_sel, cram_wr, crom_sel, crom_wr;
    logic [1:0] pad_rd;
    logic [10:0] dma_ram_addr;

    cpu_bus_decoder #(.CYC_W(CW), .RAM_AW(11)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_dummy(cpu_dummy), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cyc_count(cyc_count), .ppu_sel(ppu_sel),
        .ppu_rd(ppu_rd), .ppu_wr(ppu_wr), .ppu_rdata(ppu_rdata), .pad_rd(pad_rd),
        .pad_wr(pad_wr), .pad0_rdata(pad0_rdata), .pad1_rdata(pad1_rdata),
        .dma_go(dma_go), .dma_page(dma_page), .dma_ram_addr(dma_ram_addr),
        .dma_ram_rdata(dma_ram_rdata), .cram_sel(cram_sel), .cram_wr(cram_wr),
        .cram_rdata(cram_rdata), .crom_sel(crom_sel), .crom_wr(crom_wr),
        .crom_rdata(crom_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // behavioural reference state
    logic [7:0]    m_ram [2048];
    bit            m_known [2048];
    logic [CW-1:0] m_cnt = '0;
    bit            m_go = 1'b0;
    logic [7:0]    m_page = 8'h00;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit req, input bit we, input bit dm, input logic [15:0] a,
                        input logic [7:0] d, input logic [10:0] da);
        int ai;
        bit rd, rrd, wr, r_ram, r_ppu, r_p0, r_p1, r_cram, r_crom, r_dma, skip;
        logic [7:0] exp;
        string tg, sg;
        @(negedge clk);
        cpu_req = req; cpu_we = we; cpu_dummy = dm; cpu_addr = a; cpu_wdata = d;
        dma_ram_addr = da;
        ppu_rdata = 8'($urandom); pad0_rdata = 8'($urandom); pad1_rdata = 8'($urandom);
        cram_rdata = 8'($urandom); crom_rdata = 8'($urandom);
        #1;
        ai = int'(a);
        r_ram  = ai < 'h2000;
        r_ppu  = ai >= 'h2000 && ai < 'h4000;
        r_dma  = ai == 'h4014;
        r_p0   = ai == 'h4016;
        r_p1   = ai == 'h4017;
        r_cram = ai >= 'h6000 && ai < 'h8000;
        r_crom = ai >= 'h8000;
        rd = req && !we; rrd = rd && !dm; wr = req && we;
        skip = 1'b0;
        if (r_ram) begin
            tg = "R1"; skip = !m_known[ai & 'h7ff]; exp = m_ram[ai & 'h7ff];
        end
        else if (r_ppu)  begin tg = "R2"; exp = ppu_rdata;  end
        else if (r_p0)   begin tg = "R7"; exp = pad0_rdata; end
        else if (r_p1)   begin tg = "R7"; exp = pad1_rdata; end
        else if (r_cram) begin tg = "R3"; exp = cram_rdata; end
        else if (r_crom) begin tg = "R4"; exp = crom_rdata; end
        else             begin tg = "R8"; exp = 8'h00;      end
        if (!skip) chk(tg, "cpu_rdata", cpu_rdata, exp);
        chk("R2", "ppu_sel", ppu_sel, r_ppu);
        chk("R3", "cram_sel", cram_sel, r_cram);
        chk("R4", "crom_sel", crom_sel, r_crom);
        sg = req ? "" : "R12 ";
        chk({sg, "R2"}, "ppu_rd", ppu_rd, rd && r_ppu);
        chk({sg, "R2"}, "ppu_wr", ppu_wr, wr && r_ppu);
        chk(dm ? {sg, "R11"} : {sg, "R7"}, "pad_rd", pad_rd, {rrd && r_p1, rrd && r_p0});
        chk({sg, "R7"}, "pad_wr", pad_wr, wr && r_p0);
        chk({sg, "R3"}, "cram_wr", cram_wr, wr && r_cram);
        chk({sg, "R5"}, "crom_wr", crom_wr, wr && r_crom);
        chk("R6", "dma_go", dma_go, m_go);
        chk("R6", "dma_page", dma_page, m_page);
        chk(req ? "R9" : "R10", "cyc_count", cyc_count, m_cnt);
        if (m_known[da]) chk("R10", "dma_ram_rdata", dma_ram_rdata, m_ram[da]);
        @(posedge clk);
        if (wr && r_ram) begin m_ram[ai & 'h7ff] = d; m_known[ai & 'h7ff] = 1'b1; end
        m_go = wr && r_dma;
        if (m_go) m_page = d;
        if (req) m_cnt = m_cnt + 1'b1;
    endtask

    function automatic logic [15:0] pick_addr();
        case ($urandom % 8)
            0: return 16'($urandom % 'h2000);
            1: return 16'('h2000 + $urandom % 'h2000);
            2: return 16'('h4013 + $urandom % 6);
            3: return 16'('h4000 + $urandom % 'h2000);
            4: return 16'('h6000 + $urandom % 'h2000);
            5: return 16'('h8000 + $urandom % 'h8000);
            6: return 16'('h4014);
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_dummy = 0; cpu_addr = '0; cpu_wdata = '0;
        dma_ram_addr = '0; ppu_rdata = '0; pad0_rdata = '0; pad1_rdata = '0;
        cram_rdata = '0; crom_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R13", "cyc_count", cyc_count, 0);
        chk("R13", "dma_go", dma_go, 0);
        chk("R13", "dma_page", dma_page, 0);
        rst_n = 1'b1;

        // idle bus: no strobes (R12)
        for (int i = 0; i < 40; i++) step(0, i % 2, i % 3 == 0, pick_addr(), 8'($urandom), 11'($urandom));

        // fill RAM through rotating mirrors (R1)
        for (int i = 0; i < 2048; i++)
            step(1, 1, 0, 16'(i | ((i % 4) << 11)), 8'($urandom), 11'($urandom));

        // read back through other mirrors (R1, R10)
        for (int i = 0; i < 300; i++)
            step(1, 0, 0, 16'($urandom % 'h2000), 8'h00, 11'($urandom));

        // region edges, read and write (R2..R8)
        foreach (edges[k]) begin
            step(1, 0, 0, edges[k], 8'h00, 11'($urandom));
            step(1, 1, 0, edges[k], 8'($urandom), 11'($urandom));
            step(1, 0, 1, edges[k], 8'h00, 11'($urandom));
        end

        // back-to-back DMA triggers, then a gap (R6)
        step(1, 1, 0, 16'h4014, 8'h02, 11'd0);
        step(1, 1, 0, 16'h4014, 8'h07, 11'd1);
        step(1, 0, 0, 16'h4014, 8'hAA, 11'd2);
        step(0, 1, 0, 16'h4014, 8'h55, 11'd3);
        step(1, 1, 0, 16'h4015, 8'h33, 11'd4);

        // dummy reads on controllers and graphics window (R11, R2)
        for (int i = 0; i < 20; i++)
            step(1, 0, 1, (i % 3 == 0) ? 16'h4016 : (i % 3 == 1) ? 16'h4017 : 16'h2002, 8'h00, 11'($urandom));

        // mixed traffic, counter wraps (R9)
        for (int i = 0; i < 3000; i++)
            step(($urandom % 5) != 0, ($urandom % 3) == 0, ($urandom % 4) == 0,
                 pick_addr(), 8'($urandom), 11'($urandom));

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    logic [15:0] edges [16] = '{16'h0000, 16'h07FF, 16'h1FFF, 16'h2000, 16'h3FFF, 16'h4000,
                                16'h4013, 16'h4014, 16'h4015, 16'h4016, 16'h4017, 16'h4018,
                                16'h5FFF, 16'h6000, 16'h7FFF, 16'h8000};

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule